// File: doc/BRIEF.md
# Trail Trace Identifier Mismatch Detector

This block raises a trace identifier mismatch flag when the receive trail trace identifier, already accepted by upstream persistence filtering, disagrees with an expected identifier that the host programs. The receive identifier arrives as a flat vector of bytes held steady by its producer. A one-cycle strobe marks each acceptance of a new receive identifier. The expected identifier is kept inside the block in a small byte-wide register file. Each lane is written through a 4-bit address, a data byte and a write strobe.

Each byte is compared on its seven low bits only. The top bit of every byte is the multiframe alignment bit, the first bit received in the byte, and it takes no part in the comparison. A comparison runs after every receive update and after every expected-byte write, and its result is kept. The mismatch output is a register. It is forced low while the comparison is switched off and while multiframe alignment is off. It stays low after reset until the first receive identifier update with the valid flag high has been seen.

Top module: `ttm_detect`

## Requirements
- R1: Receive byte i sits at `rx_id[8*i +: 8]`. Only bits [6:0] of each receive byte and each expected byte are compared. A difference confined to bit 7 of any byte never sets `tim`.
- R2: Once armed and enabled, `tim` is 1 two clock edges after a trigger (`rx_upd` or `exp_wr` sampled high) if any byte differs in bits [6:0]. Under the same conditions it is 0 if all bytes agree.
- R3: A write with `exp_wr` high stores `exp_wdata` as expected byte `exp_addr`, where address 0 is the byte compared with `rx_id[7:0]` and address 15 the one compared with `rx_id[127:120]`. The new value takes effect in the next comparison.
- R4: With `cmp_en` low, `tim` is 0 from the first clock edge after `cmp_en` is sampled low.
- R5: With `mf_align_en` low, `tim` is 0 from the first clock edge after it is sampled low, whatever `cmp_en` is.
- R6: After reset, `tim` stays 0 until an edge at which `rx_upd` and `rx_valid` are both high. `tim` is also 0 while `rx_valid` is low.
- R7: Changes of `rx_id` without an `rx_upd` strobe do not change `tim`.
- R8: When both enables return high, `tim` shows the result of the latest comparison one edge later. This includes comparisons triggered while the enables were low.
- R9: Reset (`rst_n` low) clears `tim` and sets every expected byte to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_id | input | NUM_BYTES*BYTE_W | Accepted receive identifier, byte i at bits [8i+7:8i] |
| rx_valid | input | 1 | Receive identifier is valid |
| rx_upd | input | 1 | One-cycle strobe: receive identifier was updated |
| exp_wr | input | 1 | Expected byte write strobe |
| exp_addr | input | ADDR_W | Expected byte index |
| exp_wdata | input | BYTE_W | Expected byte value |
| cmp_en | input | 1 | Comparison enable |
| mf_align_en | input | 1 | Multiframe alignment enable; low forces comparison off |
| tim | output | 1 | Registered trace identifier mismatch status |

## Verification
The bench builds the block with its defaults: 16 lanes of 8 bits, 7 compared bits and a 4-bit address. Writes to lane 0 and lane 15 therefore reach both ends of the register file and of the lane vector. With the 7-bit compare width, an alignment-bit-only difference sits in bit 7 of every byte. The bench uses that to show the alignment bit is ignored in every lane at once.

// File: rtl/ttm_pkg.sv
package ttm_pkg;

    // Control state of the mismatch detector
    typedef struct packed {
        logic armed;   // a valid receive update has been seen since reset
        logic pend;    // a comparison is due this cycle
        logic mis;     // result of the latest comparison
        logic tim;     // registered mismatch output
    } ttm_state_t;

endpackage

// File: rtl/ttm_exp_store.sv
module ttm_exp_store #(
    parameter int NUM_BYTES = 16,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [NUM_BYTES*BYTE_W-1:0] exp_flat
);

    logic [BYTE_W-1:0] lane_d [NUM_BYTES];
    logic [BYTE_W-1:0] lane_q [NUM_BYTES];

    always_comb begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            lane_d[i] = lane_q[i];
            if (wr && addr == ADDR_W'(i)) begin
                lane_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (!rst_n) lane_q[i] <= '0;
            else        lane_q[i] <= lane_d[i];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_BYTES; g++) begin : g_lane
            assign exp_flat[g*BYTE_W +: BYTE_W] = lane_q[g];

            // R3: a write lands in the addressed lane
            p_store_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && addr == ADDR_W'(g)) |=> (lane_q[g] == $past(wdata)));

            // R3: lanes not addressed keep their value
            p_store_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr && addr == ADDR_W'(g)) |=> $stable(lane_q[g]));
        end
    endgenerate

endmodule

// File: rtl/ttm_lane_cmp.sv
module ttm_lane_cmp #(
    parameter int NUM_BYTES = 16,
    parameter int BYTE_W    = 8,
    parameter int CMP_W     = 7
) (
    input  logic [NUM_BYTES*BYTE_W-1:0] rx_flat,
    input  logic [NUM_BYTES*BYTE_W-1:0] exp_flat,
    output logic [NUM_BYTES-1:0]        lane_miss,
    output logic                        any_miss
);

    // Only the low CMP_W bits of each byte take part; upper bits carry alignment
    localparam logic [BYTE_W-1:0] CMP_MASK = BYTE_W'((1 << CMP_W) - 1);

    genvar g;
    generate
        for (g = 0; g < NUM_BYTES; g++) begin : g_cmp
            logic [BYTE_W-1:0] diff;
            assign diff         = (rx_flat[g*BYTE_W +: BYTE_W] ^ exp_flat[g*BYTE_W +: BYTE_W]) & CMP_MASK;
            assign lane_miss[g] = |diff;
        end
    endgenerate

    assign any_miss = |lane_miss;

endmodule

// File: rtl/ttm_detect.sv
module ttm_detect
    import ttm_pkg::*;
#(
    parameter int NUM_BYTES = 16,
    parameter int BYTE_W    = 8,
    parameter int CMP_W     = 7,
    parameter int ADDR_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BYTES*BYTE_W-1:0] rx_id,
    input  logic                        rx_valid,
    input  logic                        rx_upd,
    input  logic                        exp_wr,
    input  logic [ADDR_W-1:0]           exp_addr,
    input  logic [BYTE_W-1:0]           exp_wdata,
    input  logic                        cmp_en,
    input  logic                        mf_align_en,
    output logic                        tim
);

    logic [NUM_BYTES*BYTE_W-1:0] exp_flat;
    logic [NUM_BYTES-1:0]        lane_miss;
    logic                        any_miss;
    logic                        active;
    logic                        result;
    ttm_state_t                  st_d;
    ttm_state_t                  st_q;

    ttm_exp_store #(
        .NUM_BYTES (NUM_BYTES),
        .BYTE_W    (BYTE_W),
        .ADDR_W    (ADDR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (exp_wr),
        .addr     (exp_addr),
        .wdata    (exp_wdata),
        .exp_flat (exp_flat)
    );

    ttm_lane_cmp #(
        .NUM_BYTES (NUM_BYTES),
        .BYTE_W    (BYTE_W),
        .CMP_W     (CMP_W)
    ) u_cmp (
        .rx_flat   (rx_id),
        .exp_flat  (exp_flat),
        .lane_miss (lane_miss),
        .any_miss  (any_miss)
    );

    always_comb begin
        st_d       = st_q;
        active     = cmp_en && mf_align_en && rx_valid && st_q.armed;
        result     = st_q.pend ? any_miss : st_q.mis;
        st_d.armed = st_q.armed || (rx_upd && rx_valid);
        st_d.pend  = rx_upd || exp_wr;
        st_d.mis   = result;
        st_d.tim   = active && result;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tim = st_q.tim;

    // R4: comparison switched off forces the flag low
    p_cmp_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> !tim);

    // R5: alignment off forces the flag low
    p_align_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_align_en |=> !tim);

    // R6: no mismatch before a valid receive update
    p_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> !tim);

    // R6: once armed, the block stays armed until reset
    p_armed_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |=> st_q.armed);

    // R7: without a trigger an asserted flag holds while enabled
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tim && !st_q.pend && active) |=> tim);

    // R2: a pending comparison with a lane miss raises the flag when enabled
    p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && active && (lane_miss != '0)) |=> tim);

endmodule

// File: tb/ttm_detect_tb.sv
module ttm_detect_tb;

    localparam int NB = 16;
    localparam int BW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NB*BW-1:0] rx_id = '0;
    logic            rx_valid = 1'b0;
    logic            rx_upd = 1'b0;
    logic            exp_wr = 1'b0;
    logic [3:0]      exp_addr = '0;
    logic [BW-1:0]   exp_wdata = '0;
    logic            cmp_en = 1'b0;
    logic            mf_align_en = 1'b0;
    logic            tim;

    logic [BW-1:0]   m_exp [NB];
    int              n_chk = 0;
    int              n_bad = 0;
    bit              done = 0;

    always #2 clk = ~clk;

    ttm_detect u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_id       (rx_id),
        .rx_valid    (rx_valid),
        .rx_upd      (rx_upd),
        .exp_wr      (exp_wr),
        .exp_addr    (exp_addr),
        .exp_wdata   (exp_wdata),
        .cmp_en      (cmp_en),
        .mf_align_en (mf_align_en),
        .tim         (tim)
    );

    task automatic chk(input string tag, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: tim actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    // Independent model: mismatch on the seven low bits of any lane
    function automatic logic model_miss(input logic [NB*BW-1:0] id);
        logic m = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (id[i*BW +: 7] != m_exp[i][6:0]) m = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [NB*BW-1:0] fill(input logic [BW-1:0] b);
        logic [NB*BW-1:0] v;
        for (int i = 0; i < NB; i++) v[i*BW +: BW] = b;
        return v;
    endfunction

    task automatic do_upd(input logic [NB*BW-1:0] id);
        @(negedge clk);
        rx_id  = id;
        rx_upd = 1'b1;
        @(negedge clk);
        rx_upd = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        exp_wr    = 1'b1;
        exp_addr  = a;
        exp_wdata = d;
        m_exp[a]  = d;
        @(negedge clk);
        exp_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NB; i++) m_exp[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 reset clears tim", tim, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_unarmed;
        cmp_en = 1'b1;
        mf_align_en = 1'b1;
        rx_valid = 1'b0;
        do_upd(fill(8'h33));
        chk("R6 update with rx_valid low does not arm", tim, 1'b0);
        @(negedge clk);
        rx_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 valid without update does not arm", tim, 1'b0);
    endtask

    task automatic t_mismatch;
        logic [NB*BW-1:0] id = '0;
        id[3*BW +: BW] = 8'h05;
        do_upd(id);
        chk("R2 low-bit difference in lane 3", tim, model_miss(id));
        do_upd('0);
        chk("R2/R9 all-zero id matches reset expected", tim, 1'b0);
    endtask

    task automatic t_align_bit;
        do_upd(fill(8'h80));
        chk("R1 bit 7 differences in all lanes ignored", tim, model_miss(fill(8'h80)));
    endtask

    task automatic t_write;
        logic [NB*BW-1:0] id = fill(8'h80);
        do_wr(4'd15, 8'h41);
        chk("R3 write lane 15 causes mismatch", tim, 1'b1);
        id[15*BW +: BW] = 8'hC1;
        do_upd(id);
        chk("R1/R3 lane 15 matches low bits", tim, model_miss(id));
        do_wr(4'd0, 8'h7F);
        chk("R3 write lane 0 causes mismatch", tim, model_miss(id));
        do_wr(4'd0, 8'h80);
        chk("R1/R3 lane 0 alignment-only difference", tim, model_miss(id));
    endtask

    task automatic t_no_reeval;
        @(negedge clk);
        rx_id = fill(8'h5A);
        repeat (3) @(negedge clk);
        chk("R7 id change without strobe ignored (low)", tim, 1'b0);
        do_upd(fill(8'h5A));
        chk("R2 strobe applies new id", tim, 1'b1);
        @(negedge clk);
        rx_id = '0;
        rx_id[15*BW +: BW] = 8'h41;
        repeat (3) @(negedge clk);
        chk("R7 id change without strobe ignored (high)", tim, 1'b1);
    endtask

    task automatic t_enables;
        @(negedge clk);
        cmp_en = 1'b0;
        @(negedge clk);
        chk("R4 compare disabled", tim, 1'b0);
        cmp_en = 1'b1;
        @(negedge clk);
        chk("R8 compare re-enabled restores", tim, 1'b1);
        mf_align_en = 1'b0;
        @(negedge clk);
        chk("R5 alignment disabled", tim, 1'b0);
        cmp_en = 1'b1;
        do_upd(fill(8'h5A));
        chk("R5 update while alignment off stays low", tim, 1'b0);
        mf_align_en = 1'b1;
        @(negedge clk);
        chk("R8 alignment re-enabled restores", tim, 1'b1);
        cmp_en = 1'b0;
        for (int i = 0; i < NB; i++) do_wr(4'(i), 8'h5A);
        chk("R4 writes while disabled keep low", tim, 1'b0);
        cmp_en = 1'b1;
        @(negedge clk);
        chk("R8 result from disabled-time writes", tim, model_miss(fill(8'h5A)));
        rx_valid = 1'b0;
        do_upd(fill(8'h11));
        chk("R6 rx_valid low holds tim low", tim, 1'b0);
    endtask

    initial begin
        t_reset;
        t_unarmed;
        t_mismatch;
        t_align_bit;
        t_write;
        t_no_reeval;
        t_enables;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule